// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Table

This block applies gamma correction to the pixel streams of three display channels. Each channel carries 24-bit pixels made of red, green and blue components of 8 bits. When a channel's gamma enable is set, every component is replaced by the entry it selects in that channel's own 256-entry table for that colour. When the enable is clear, the pixel passes through untouched. In both cases the pixel, its valid flag and its two sync bits leave the block one clock after they enter.

All nine tables live in one flat memory of 2304 bytes. Software fills it through a small load port: an address write sets the load pointer and an auto-increment flag, and each data write stores one byte at the pointer. Memory is ordered by channel, and within a channel by colour (red, then green, then blue). When all three enables are clear at the same time the memory is treated as powered down. It then ignores writes, and its contents fall back to the identity mapping.

Top module: `gamma_lut`

## Requirements
- R1: An address write (`cfgAddrWe`) loads the load pointer from `cfgAddrIn` and the auto-increment flag from `cfgAutoIncIn`. A data write (`cfgDataWe`) stores `cfgDataIn` at the pointer.
- R2: With the auto-increment flag set, each data write advances the pointer by one.
- R3: With the auto-increment flag clear, a data write leaves the pointer unchanged, so repeated writes hit the same entry and the last value wins.
- R4: When auto-increment is set, a data write at pointer 2303 wraps the pointer to 0.
- R5: The table entry for channel c, colour k (red=0, green=1, blue=2) and input value v is at address c*768 + k*256 + v.
- R6: Channel c occupies bits [24c+23:24c] of the pixel buses, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0 of that slice. With `gammaEn[c]` set, each component is replaced by its table entry.
- R7: With `gammaEn[c]` clear, channel c's pixel leaves the block unchanged, whatever the table holds.
- R8: Output data, valid and sync follow the input by exactly one clock, and each reset to 0.
- R9: After reset every entry reads as the identity mapping: the entry at offset v within a colour block holds v.
- R10: While `gammaEn` is all zero, data writes are ignored (the pointer still moves as in R2 to R4), and all contents return to the identity mapping.
- R11: A lookup in the same cycle as a write to the same entry returns the old value. The new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddrWe | input | 1 | Load-pointer write strobe |
| cfgAddrIn | input | 12 | New load pointer value |
| cfgAutoIncIn | input | 1 | Auto-increment flag, taken with the pointer |
| cfgDataWe | input | 1 | Table data write strobe |
| cfgDataIn | input | 8 | Table byte to store |
| gammaEn | input | 3 | Per-channel gamma enable |
| pixValidIn | input | 3 | Per-channel pixel valid |
| pixSyncIn | input | 6 | Two sync bits per channel, passed along |
| pixDataIn | input | 72 | Three 24-bit pixels |
| pixValidOut | output | 3 | Delayed pixel valid |
| pixSyncOut | output | 6 | Delayed sync bits |
| pixDataOut | output | 72 | Corrected or bypassed pixels |

## Verification
The collision between a load-port write and a lookup of the same entry is the hardest case to reach. The bench reaches it by pointing the load port at a non-incrementing address and then presenting, on the same falling edge, a data write and a pixel whose blue component selects that entry. It then holds the pixel for a second cycle to see the new value. The pointer wrap is reached by streaming all 2304 entries with auto-increment and writing once more; the wrapped write lands in channel 0's first red entry. The power-down case drops all enables while writes are issued, then re-enables the channels and sweeps lookups that show identity data.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int NUM_CH   = 3;
  localparam int COMP_W   = 8;
  localparam int NUM_COMP = 3;
  localparam int SYNC_W   = 2;
  localparam int TBL_LEN  = 1 << COMP_W;
  localparam int CH_SPAN  = NUM_COMP * TBL_LEN;
  localparam int DEPTH    = NUM_CH * CH_SPAN;
  localparam int ADDR_W   = $clog2(DEPTH);
  localparam int PIX_W    = NUM_COMP * COMP_W;

  // strobes from the load-port control into the table datapath
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [COMP_W-1:0] wrData;
    logic              powerDown;
  } lutCtl_t;
endpackage

// File: rtl/gamma_lut_ctl.sv
module gamma_lut_ctl
  import gamma_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgAddrWe,
  input  logic [ADDR_W-1:0] cfgAddrIn,
  input  logic              cfgAutoIncIn,
  input  logic              cfgDataWe,
  input  logic [COMP_W-1:0] cfgDataIn,
  input  logic [NUM_CH-1:0] gammaEn,
  output lutCtl_t           ctl
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addrQ;
  logic              autoIncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      autoIncQ <= 1'b0;
    end else if (cfgAddrWe) begin
      addrQ    <= cfgAddrIn;
      autoIncQ <= cfgAutoIncIn;
    end else if (cfgDataWe && autoIncQ) begin
      addrQ <= (addrQ == LAST_ADDR) ? '0 : addrQ + 1'b1;
    end
  end

  always_comb begin
    ctl.powerDown = (gammaEn == '0);
    ctl.wrEn      = cfgDataWe && !ctl.powerDown;
    ctl.wrAddr    = addrQ;
    ctl.wrData    = cfgDataIn;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDataWe && autoIncQ && !cfgAddrWe && addrQ != LAST_ADDR) |=> addrQ == $past(addrQ) + 1'b1) // R2
    else $error("pointer did not advance");
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDataWe && !autoIncQ && !cfgAddrWe) |=> $stable(addrQ)) // R3
    else $error("pointer moved without auto-increment");
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDataWe && autoIncQ && !cfgAddrWe && addrQ == LAST_ADDR) |=> addrQ == '0) // R4
    else $error("pointer did not wrap");
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgAddrWe |=> addrQ == $past(cfgAddrIn)) // R1
    else $error("pointer load lost");
endmodule

// File: rtl/gamma_lut_dp.sv
module gamma_lut_dp
  import gamma_lut_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  lutCtl_t                  ctl,
  input  logic [NUM_CH-1:0]        gammaEn,
  input  logic [NUM_CH-1:0]        pixValidIn,
  input  logic [NUM_CH*SYNC_W-1:0] pixSyncIn,
  input  logic [NUM_CH*PIX_W-1:0]  pixDataIn,
  output logic [NUM_CH-1:0]        pixValidOut,
  output logic [NUM_CH*SYNC_W-1:0] pixSyncOut,
  output logic [NUM_CH*PIX_W-1:0]  pixDataOut
);
  logic [COMP_W-1:0] tblMem [DEPTH];
  logic [DEPTH-1:0]  entryValid;
  logic [NUM_CH*PIX_W-1:0] nextPix;

  wire inRange = (ctl.wrAddr < ADDR_W'(DEPTH));

  // storage has no reset; validity bits supply the identity default
  always_ff @(posedge clk) begin
    if (ctl.wrEn && inRange) tblMem[ctl.wrAddr] <= ctl.wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.powerDown) entryValid <= '0;
    else if (ctl.wrEn && inRange) entryValid[ctl.wrAddr] <= 1'b1;
  end

  function automatic logic [COMP_W-1:0] readEntry(input logic [ADDR_W-1:0] a);
    return entryValid[a] ? tblMem[a] : a[COMP_W-1:0];
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PIX_W-1:0] mapped;
    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
      localparam int SLOT = (NUM_COMP - 1 - k) * COMP_W;
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * CH_SPAN + k * TBL_LEN);
      logic [ADDR_W-1:0] rdAddr;
      always_comb begin
        rdAddr = BASE | ADDR_W'(pixDataIn[c*PIX_W + SLOT +: COMP_W]);
        mapped[SLOT +: COMP_W] = readEntry(rdAddr);
      end
    end
    assign nextPix[c*PIX_W +: PIX_W] = gammaEn[c] ? mapped : pixDataIn[c*PIX_W +: PIX_W];

    AST_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
      !gammaEn[c] |=> pixDataOut[c*PIX_W +: PIX_W] == $past(pixDataIn[c*PIX_W +: PIX_W])) // R7
      else $error("bypass altered pixel");
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValidOut <= '0;
      pixSyncOut  <= '0;
      pixDataOut  <= '0;
    end else begin
      pixValidOut <= pixValidIn;
      pixSyncOut  <= pixSyncIn;
      pixDataOut  <= nextPix;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pixValidOut == $past(pixValidIn)) // R8
    else $error("valid latency wrong");
  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pixSyncOut == $past(pixSyncIn)) // R8
    else $error("sync latency wrong");
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgAddrWe,
  input  logic [ADDR_W-1:0]        cfgAddrIn,
  input  logic                     cfgAutoIncIn,
  input  logic                     cfgDataWe,
  input  logic [COMP_W-1:0]        cfgDataIn,
  input  logic [NUM_CH-1:0]        gammaEn,
  input  logic [NUM_CH-1:0]        pixValidIn,
  input  logic [NUM_CH*SYNC_W-1:0] pixSyncIn,
  input  logic [NUM_CH*PIX_W-1:0]  pixDataIn,
  output logic [NUM_CH-1:0]        pixValidOut,
  output logic [NUM_CH*SYNC_W-1:0] pixSyncOut,
  output logic [NUM_CH*PIX_W-1:0]  pixDataOut
);
  lutCtl_t ctl;

  gamma_lut_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgAddrWe(cfgAddrWe), .cfgAddrIn(cfgAddrIn), .cfgAutoIncIn(cfgAutoIncIn),
    .cfgDataWe(cfgDataWe), .cfgDataIn(cfgDataIn),
    .gammaEn(gammaEn), .ctl(ctl)
  );

  gamma_lut_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .gammaEn(gammaEn),
    .pixValidIn(pixValidIn), .pixSyncIn(pixSyncIn), .pixDataIn(pixDataIn),
    .pixValidOut(pixValidOut), .pixSyncOut(pixSyncOut), .pixDataOut(pixDataOut)
  );
endmodule

// File: tb/tb_gamma_lut.sv
module tb_gamma_lut;
  import gamma_lut_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgAddrWe = 1'b0, cfgAutoIncIn = 1'b0, cfgDataWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddrIn = '0;
  logic [COMP_W-1:0] cfgDataIn = '0;
  logic [NUM_CH-1:0] gammaEn = '0;
  logic [NUM_CH-1:0] pixValidIn = '0;
  logic [NUM_CH*SYNC_W-1:0] pixSyncIn = '0;
  logic [NUM_CH*PIX_W-1:0] pixDataIn = '0;
  logic [NUM_CH-1:0] pixValidOut;
  logic [NUM_CH*SYNC_W-1:0] pixSyncOut;
  logic [NUM_CH*PIX_W-1:0] pixDataOut;

  int total = 0;
  int bad = 0;
  int model [DEPTH];
  int bAddr = 0;
  bit bInc = 0;

  always #5 clk = ~clk;

  gamma_lut dut (.*);

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setAddr(input int a, input bit inc);
    @(negedge clk);
    cfgAddrWe = 1'b1; cfgAddrIn = ADDR_W'(a); cfgAutoIncIn = inc;
    @(negedge clk);
    cfgAddrWe = 1'b0;
    bAddr = a; bInc = inc;
  endtask

  // model per R1-style rules: store unless powered down, then move pointer
  task automatic writeData(input int d);
    @(negedge clk);
    cfgDataWe = 1'b1; cfgDataIn = COMP_W'(d);
    @(negedge clk);
    cfgDataWe = 1'b0;
    if (gammaEn != '0) model[bAddr] = d & 255;
    if (bInc) bAddr = (bAddr == DEPTH - 1) ? 0 : bAddr + 1;
  endtask

  function automatic logic [23:0] expPix(input int c, input logic [23:0] p);
    if (!gammaEn[c]) return p;
    return {8'(model[c*CH_SPAN + 0*TBL_LEN + p[23:16]]),
            8'(model[c*CH_SPAN + 1*TBL_LEN + p[15:8]]),
            8'(model[c*CH_SPAN + 2*TBL_LEN + p[7:0]])};
  endfunction

  task automatic lookPix(input string tag, input int r, input int g, input int b);
    logic [23:0] p;
    p = {8'(r), 8'(g), 8'(b)};
    @(negedge clk);
    pixDataIn = {p, p, p};
    pixValidIn = '1;
    @(negedge clk);
    for (int c = 0; c < NUM_CH; c++)
      check(tag, 72'(pixDataOut[c*PIX_W +: PIX_W]), 72'(expPix(c, p)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = a % TBL_LEN;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset valid", 72'(pixValidOut), 72'(0));
    check("R8 reset data", 72'(pixDataOut), 72'(0));

    // R9: identity tables after reset, all channels mapped
    gammaEn = 3'b111;
    for (int v = 0; v < 256; v++) lookPix("R9 identity", v, v ^ 8'h5A, 255 - v);

    // R1 R2 R5: stream every entry with auto-increment from address 0
    setAddr(0, 1);
    for (int a = 0; a < DEPTH; a++) writeData((a * 37 + 11) & 255);
    for (int v = 0; v < 256; v++) lookPix("R5 R6 loaded", v, v ^ 8'h5A, 255 - v);

    // R4: pointer has wrapped to 0; next byte lands in channel 0 red entry 0
    writeData(8'hA5);
    lookPix("R4 wrap", 0, 0, 0);
    check("R4 wrap red", 72'(pixDataOut[23:16]), 72'(8'hA5));

    // R3: no auto-increment, last of three writes wins at ch1 green entry 10
    setAddr(CH_SPAN + TBL_LEN + 10, 0);
    writeData(8'h11); writeData(8'h22); writeData(8'h77);
    lookPix("R3 same entry", 0, 10, 0);
    check("R3 last value", 72'(pixDataOut[PIX_W + 8 +: 8]), 72'(8'h77));
    lookPix("R3 neighbour", 0, 11, 0);

    // R7: only channel 1 mapped
    gammaEn = 3'b010;
    for (int v = 0; v < 256; v += 3) lookPix("R7 bypass", v, 255 - v, v ^ 8'hC3);
    gammaEn = 3'b101;
    for (int v = 1; v < 256; v += 5) lookPix("R7 bypass mix", 255 - v, v, v);
    gammaEn = 3'b111;

    // R8: one-cycle latency of valid and sync
    @(negedge clk);
    pixValidIn = '0; pixSyncIn = '0;
    @(negedge clk);
    pixValidIn = 3'b101; pixSyncIn = 6'b100111;
    #1;
    check("R8 not early", 72'(pixValidOut), 72'(0));
    @(negedge clk);
    check("R8 valid", 72'(pixValidOut), 72'(3'b101));
    check("R8 sync", 72'(pixSyncOut), 72'(6'b100111));
    pixValidIn = '0; pixSyncIn = 6'b010000;
    @(negedge clk);
    check("R8 valid drop", 72'(pixValidOut), 72'(0));
    check("R8 sync next", 72'(pixSyncOut), 72'(6'b010000));

    // R11: write and lookup of ch0 blue entry 7 in the same cycle
    setAddr(2 * TBL_LEN + 7, 0);
    @(negedge clk);
    pixDataIn = {3{24'h000007}};
    pixValidIn = '1;
    cfgDataWe = 1'b1; cfgDataIn = 8'hC3;
    @(negedge clk);
    cfgDataWe = 1'b0;
    check("R11 old value", 72'(pixDataOut[7:0]), 72'(model[2*TBL_LEN + 7]));
    model[2*TBL_LEN + 7] = 8'hC3;
    @(negedge clk);
    check("R11 new value", 72'(pixDataOut[7:0]), 72'(8'hC3));

    // R10: all enables clear, writes ignored, contents back to identity
    gammaEn = '0;
    setAddr(5, 1);
    writeData(8'h33);
    check("R10 pointer moved", 72'(bAddr), 72'(6));
    for (int a = 0; a < DEPTH; a++) model[a] = a % TBL_LEN;
    gammaEn = 3'b111;
    for (int v = 0; v < 256; v += 5) lookPix("R10 identity", v, 255 - v, v);
    writeData(8'h44);
    lookPix("R10 pointer after", 6, 0, 0);
    check("R10 pointer after red", 72'(pixDataOut[23:16]), 72'(8'h44));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule